// File: doc/BRIEF.md
# Slow-Port Wait-State Sequencer with Ready Pause

This block carries single read or write requests from a core-side port to a memory-mapped I/O device on a slow external bus. It latches the request, the timing and the pause settings when it accepts the request. It then steps a state counter through three phases: setup, strobe and hold. The counter advances once every two core cycles, because the external bus runs at half the core rate. Chip-enable stays asserted for the whole access. The read or write strobe is asserted only while the counter is in the strobe phase.

A ready-pause option lets a slow device stretch an access. When the option is enabled, the counter halts at a programmed state value. It holds there, with every strobe steady, until the device drives its asynchronous active-low ready line low. The ready line passes through a two-flop synchronizer before the counter uses it. A width strap is sampled during reset and selects a 32-bit or a 16-bit device. In 16-bit mode each core access becomes two external accesses, low half first, and the addressable region halves.

Top module: `slowport_seq`

## Requirements
- R1: While reset is held and just after it, `idle` is 1, `done` is 0 and `ext_ce_n`, `ext_rd_n` and `ext_wr_n` are all 1.
- R2: With the pause option off, an access lasts L = setup + strobe + hold states of two core cycles each. `done` is high in the core cycle that follows the edge 2·L edges after the accepting edge (4·L in 16-bit mode). The values of `cfg_pause` and `ext_rdy_n` have no effect.
- R3: `ext_ce_n` is low for every cycle of an access. `ext_rd_n` (read) or `ext_wr_n` (write) is low only while the counter is in the strobe states, which are state numbers setup to setup+strobe−1. The two strobes are never low together.
- R4: With the pause option on, once the counter reaches `cfg_pause` and the synchronized ready is high, the counter holds. The access does not finish, and `ext_rd_n`, `ext_wr_n` and `ext_ce_n` stay unchanged.
- R5: `ext_rdy_n` passes through two flops. The counter is treated as ready only when the synchronized value is low. If ready falls just before relative edge r and pause value p is inside the sequence, the first advance from p happens at the smallest even relative edge K ≥ max(2p+2, r+2). The access then ends at edge K + 2·(L−1−p).
- R6: If `cfg_pause` is at or beyond L, no pause occurs and the length is as in R2.
- R7: With the strap high at reset, an access makes two external transfers, the low half first (`ext_addr[1]`=0, then 1), on `ext_dout[15:0]`/`ext_din[15:0]`. Read data is assembled as {second[15:0], first[15:0]} before `done`.
- R8: In 16-bit mode, `ext_addr` bit AW−1 is forced to 0 (the region shrinks to half), and `ext_addr` = {0, word address[AW−4:0], half, 0}. In 32-bit mode `ext_addr` = {word address, 00}.
- R9: `done` is a single-cycle pulse. A request is accepted only while `idle` is 1. A request raised during an access is ignored and produces no second `done`.
- R10: During a write, `ext_oe` is 1 and `ext_dout` carries the write data (32-bit mode), or its low then high half on bits 15:0 (16-bit mode).
- R11: A `cfg_strobe` value of 0 is treated as 1.
- R12: Read data is taken from `ext_din` at the edge that leaves the last strobe state. It is presented on `rdata` when `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_w16 | input | 1 | Device width strap, sampled during reset (1 = 16-bit) |
| cfg_ready_en | input | 1 | Enables the ready pause |
| cfg_pause | input | SW | State value at which the counter pauses |
| cfg_setup | input | PW | Setup states |
| cfg_strobe | input | PW | Strobe states (0 acts as 1) |
| cfg_hold | input | PW | Hold states |
| req | input | 1 | Request, accepted when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW-2 | Word address |
| req_wdata | input | DW | Write data |
| idle | output | 1 | Sequencer idle, ready to accept |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read data, valid with done |
| ext_addr | output | AW | External byte address |
| ext_dout | output | DW | External write data |
| ext_oe | output | 1 | External data drive enable |
| ext_din | input | DW | External read data |
| ext_ce_n | output | 1 | Chip-enable, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_rdy_n | input | 1 | Asynchronous ready, active low |

## Verification
The bench releases ready at an even and at an odd edge while the counter sits in a pause state. A design that miscounted the synchronizer depth, or stepped on the wrong half-rate phase, would finish one or two cycles off the computed edge. It puts the pause value beyond the sequence and also holds ready low before the request, so a design that stalled there wrongly would run long. Strobe-cycle counts expose a design that treats a zero strobe as zero length or that lets the strobe drop during a pause. In 16-bit mode, a read at a word address with the top bit set shows up any missing address clearing or swapped halves as wrong assembled data. A request raised mid-access shows up a sequencer that accepts while busy, because that produces an unexpected extra completion.

// File: rtl/slowport_seq.sv
module slowport_seq #(
  parameter int AW = 23,
  parameter int DW = 32,
  parameter int PW = 4,
  parameter int SW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_w16,
  input  logic          cfg_ready_en,
  input  logic [SW-1:0] cfg_pause,
  input  logic [PW-1:0] cfg_setup,
  input  logic [PW-1:0] cfg_strobe,
  input  logic [PW-1:0] cfg_hold,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-3:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_dout,
  output logic          ext_oe,
  input  logic [DW-1:0] ext_din,
  output logic          ext_ce_n,
  output logic          ext_rd_n,
  output logic          ext_wr_n,
  input  logic          ext_rdy_n
);
  localparam int HW = DW / 2;

  logic          w16_q, run, tk, half, we_q, en_q, done_q, rs1, rs2;
  logic [SW-1:0] st, pause_q, set_q, sen_q, last_q;
  logic [AW-3:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  wire [SW-1:0] stb_eff   = (cfg_strobe == '0) ? SW'(1) : SW'(cfg_strobe);
  wire [SW-1:0] sen_w     = SW'(cfg_setup) + stb_eff;
  wire [SW-1:0] len_w     = sen_w + SW'(cfg_hold);
  wire          stall     = en_q && (st == pause_q) && rs2;
  wire          step      = run && tk && !stall;
  wire          in_stb    = (st >= set_q) && (st < sen_q);
  wire          fin       = step && (st == last_q);
  wire          last_half = !w16_q || half;
  wire          grab      = step && !we_q && (st == sen_q - SW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w16_q   <= strap_w16;
      run     <= 1'b0;
      tk      <= 1'b0;
      half    <= 1'b0;
      we_q    <= 1'b0;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      rs1     <= 1'b1;
      rs2     <= 1'b1;
      st      <= '0;
      pause_q <= '0;
      set_q   <= '0;
      sen_q   <= '0;
      last_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      rs1    <= ext_rdy_n;
      rs2    <= rs1;
      done_q <= fin && last_half;
      if (!run) begin
        if (req) begin
          run     <= 1'b1;
          tk      <= 1'b0;
          half    <= 1'b0;
          st      <= '0;
          we_q    <= req_we;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          en_q    <= cfg_ready_en;
          pause_q <= cfg_pause;
          set_q   <= SW'(cfg_setup);
          sen_q   <= sen_w;
          last_q  <= len_w - SW'(1);
        end
      end else begin
        tk <= ~tk;
        if (fin) begin
          st <= '0;
          if (last_half) run <= 1'b0;
          else           half <= 1'b1;
        end else if (step) begin
          st <= st + SW'(1);
        end
      end
      if (grab) begin
        if (!w16_q)    rdata_q             <= ext_din;
        else if (half) rdata_q[DW-1:HW]    <= ext_din[HW-1:0];
        else           rdata_q[HW-1:0]     <= ext_din[HW-1:0];
      end
    end
  end

  assign idle     = !run;
  assign done     = done_q;
  assign rdata    = rdata_q;
  assign ext_addr = w16_q ? {1'b0, addr_q[AW-4:0], half, 1'b0} : {addr_q, 2'b00};
  assign ext_dout = w16_q ? {{HW{1'b0}}, (half ? wdata_q[DW-1:HW] : wdata_q[HW-1:0])} : wdata_q;
  assign ext_oe   = run && we_q;
  assign ext_ce_n = !run;
  assign ext_rd_n = !(run && !we_q && in_stb);
  assign ext_wr_n = !(run && we_q && in_stb);

  // R9: completion lasts exactly one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: strobes exclusive and only under chip-enable
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));
  a_r3_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> !ext_ce_n);

  // R4: a stalled tick leaves counter and strobes untouched
  a_r4_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tk && stall) |=> (run && st == $past(st) && $stable(ext_rd_n) && $stable(ext_wr_n)));

  // R9: the captured request cannot change while busy
  a_r9_busy_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(addr_q) && $stable(we_q));

  // R7: width mode fixed outside reset
  a_r7_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(w16_q));
endmodule

// File: tb/slowport_seq_tb.sv
`timescale 1ns/1ps
module slowport_seq_tb;
  logic clk = 0, rst_n = 0, strap_w16 = 0;
  logic cfg_ready_en = 0;
  logic [7:0] cfg_pause = 0;
  logic [3:0] cfg_setup = 1, cfg_strobe = 1, cfg_hold = 1;
  logic req = 0, req_we = 0;
  logic [20:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic idle, done, ext_oe, ext_ce_n, ext_rd_n, ext_wr_n;
  logic ext_rdy_n = 1;
  logic [31:0] rdata, ext_dout, ext_din;
  logic [22:0] ext_addr;

  always #5 clk = ~clk;

  slowport_seq #(.AW(23), .DW(32), .PW(4), .SW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_w16(strap_w16),
    .cfg_ready_en(cfg_ready_en), .cfg_pause(cfg_pause),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .idle(idle), .done(done), .rdata(rdata),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_oe(ext_oe), .ext_din(ext_din),
    .ext_ce_n(ext_ce_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_rdy_n(ext_rdy_n));

  function automatic [31:0] dev(input [22:0] a);
    dev = {~a[15:0], a[15:0] ^ {a[22:16], 9'h0}};
  endfunction
  assign ext_din = dev(ext_addr);

  typedef struct {
    int unsigned ecyc;
    logic [31:0] data;
    bit          rd;
    int          stbc;
    int          fcyc;
    string       tag;
  } exp_t;
  exp_t q[$];

  int unsigned cyc = 0;
  int nchk = 0, nfail = 0;
  int ce_cnt = 0, stb_cnt = 0;
  bit oe_bad = 0, m16 = 0, finished = 0;
  logic [31:0] wcap = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ext_ce_n) ce_cnt++;
      if (!ext_rd_n || !ext_wr_n) stb_cnt++;
      if (!ext_wr_n) begin
        if (!ext_oe) oe_bad = 1;
        if (m16) begin
          if (ext_addr[1]) wcap[31:16] = ext_dout[15:0];
          else             wcap[15:0]  = ext_dout[15:0];
        end else wcap = ext_dout;
      end
      if (done) begin
        if (q.size() == 0) chk(0, "R9 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.ecyc, {e.tag, " done cycle"}, cyc, e.ecyc);
          if (e.rd) chk(rdata == e.data, {e.tag, " R12 read data"}, rdata, e.data);
          else begin
            chk(wcap == e.data, {e.tag, " R10 write data"}, wcap, e.data);
            chk(!oe_bad, {e.tag, " R10 oe during write"}, oe_bad, 0);
          end
          if (e.stbc >= 0) chk(stb_cnt == e.stbc, {e.tag, " R3 strobe cycles"}, stb_cnt, e.stbc);
          chk(ce_cnt == e.fcyc, {e.tag, " R3 chip-enable cycles"}, ce_cnt, e.fcyc);
        end
        ce_cnt = 0; stb_cnt = 0; oe_bad = 0; wcap = 0;
      end
    end
  end

  task automatic do_reset(input bit w16);
    @(negedge clk);
    strap_w16 = w16; m16 = w16; rst_n = 0; req = 0; ext_rdy_n = 1;
    repeat (4) @(negedge clk);
    chk(idle && !done && ext_ce_n && ext_rd_n && ext_wr_n, "R1 state in reset",
        {idle, done, ext_ce_n, ext_rd_n, ext_wr_n}, 5'b10111);
    rst_n = 1;
    @(negedge clk);
    chk(idle && !done && ext_ce_n && ext_rd_n && ext_wr_n, "R1 state after reset",
        {idle, done, ext_ce_n, ext_rd_n, ext_wr_n}, 5'b10111);
    ce_cnt = 0; stb_cnt = 0;
  endtask

  task automatic set_cfg(input bit en, input [7:0] p, input [3:0] s, input [3:0] b, input [3:0] h);
    cfg_ready_en = en; cfg_pause = p; cfg_setup = s; cfg_strobe = b; cfg_hold = h;
  endtask

  // driver: issues one access and pushes its expected completion
  task automatic run_acc(input bit we, input [20:0] wa, input [31:0] wd, input int f,
                         input int stbc, input int p, input int rrel, input bit midreq,
                         input string tag);
    exp_t e;
    logic [22:0] a0, a2;
    int unsigned a;
    logic s_rd, s_wr;
    bit steady;
    a0 = m16 ? {1'b0, wa[19:0], 2'b00} : {wa, 2'b00};
    a2 = a0 | 23'd2;
    @(negedge clk);
    req = 1; req_we = we; req_addr = wa; req_wdata = wd;
    e.ecyc = cyc + 1 + f;
    e.rd   = !we;
    e.data = we ? wd : (m16 ? {dev(a2)[15:0], dev(a0)[15:0]} : dev(a0));
    e.stbc = stbc;
    e.fcyc = f;
    e.tag  = tag;
    q.push_back(e);
    a = cyc + 1;
    @(negedge clk);
    req = 0;
    if (midreq) begin
      while (cyc < a + 2) @(negedge clk);
      chk(!idle, "R9 busy while running", idle, 0);
      req = 1; req_we = !we; req_addr = wa ^ 21'h155;
      while (cyc < a + 4) @(negedge clk);
      req = 0;
    end
    if (rrel > 0) begin
      while (cyc < a + 2 * p + 1) @(negedge clk);
      s_rd = ext_rd_n; s_wr = ext_wr_n; steady = 1;
      while (cyc < a + rrel - 1) begin
        @(negedge clk);
        if (ext_rd_n !== s_rd || ext_wr_n !== s_wr || ext_ce_n || done) steady = 0;
      end
      chk(steady, {tag, " R4 held at pause"}, steady, 1);
      ext_rdy_n = 0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (midreq ? 20 : 3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset(0);
    // R2: pause off, L=4, pause value and ready ignored
    set_cfg(0, 8'd1, 4'd1, 4'd2, 4'd1);
    run_acc(0, 21'h0ABCD, 0, 8, 4, 0, 0, 0, "R2 read L4");
    ext_rdy_n = 0;
    run_acc(0, 21'h12345, 0, 8, 4, 0, 0, 0, "R2 read ready low ignored");
    ext_rdy_n = 1;
    // R2/R10: shortest write
    set_cfg(0, 8'd0, 4'd0, 4'd1, 4'd0);
    run_acc(1, 21'h00010, 32'hDEADBEEF, 2, 2, 0, 0, 0, "R10 write L1");
    // R11: zero strobe acts as one
    set_cfg(0, 8'd0, 4'd1, 4'd0, 4'd1);
    run_acc(0, 21'h1F00F, 0, 6, 2, 0, 0, 0, "R11 zero strobe");
    // R6: pause beyond the sequence
    set_cfg(1, 8'd50, 4'd2, 4'd3, 4'd2);
    run_acc(0, 21'h0F0F0, 0, 14, 6, 0, 0, 0, "R6 pause beyond length");
    // R4/R5: pause in strobe state 3, ready released before edge 20 -> K=22
    set_cfg(1, 8'd3, 4'd2, 4'd3, 4'd2);
    run_acc(0, 21'h03333, 0, 28, 20, 3, 20, 0, "R5 release even");
    ext_rdy_n = 1; repeat (3) @(negedge clk);
    // R5: pause in last hold state, release before odd edge 21 -> K=24
    set_cfg(1, 8'd6, 4'd2, 4'd3, 4'd2);
    run_acc(1, 21'h04444, 32'h13579BDF, 24, 6, 6, 21, 0, "R5 release odd");
    // R5: ready already low -> no stall
    set_cfg(1, 8'd3, 4'd2, 4'd3, 4'd2);
    repeat (3) @(negedge clk);
    run_acc(0, 21'h05555, 0, 14, 6, 0, 0, 0, "R5 ready low beforehand");
    ext_rdy_n = 1; repeat (3) @(negedge clk);
    // R9: request during an access is ignored
    set_cfg(0, 8'd0, 4'd1, 4'd2, 4'd1);
    run_acc(0, 21'h06666, 0, 8, 4, 0, 0, 1, "R9 busy request");
    // 16-bit mode
    do_reset(1);
    set_cfg(0, 8'd0, 4'd1, 4'd2, 4'd1);
    run_acc(0, 21'h1ABCD5, 0, 16, 8, 0, 0, 0, "R7 R8 read 16-bit top bit");
    run_acc(1, 21'h00321, 32'hCAFEF00D, 16, 8, 0, 0, 0, "R7 R10 write 16-bit");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule